// File: doc/BRIEF.md
# Dual-Channel Countdown Timer

This block is a timer peripheral with two independent channels behind a simple register bus. The bus has an address, write data, a write strobe and combinational read data. Each channel holds a 64-bit interval, split into a low and a high 32-bit word, and a 64-bit down-counter that can be read the same way. A control word per channel starts the count, picks a power-of-two prescaler, and chooses between stopping at zero and reloading automatically.

A channel raises a sticky status flag when its count reaches zero. Software clears the flag by writing a one to its bit. A shared enable mask combines the flags into one interrupt line. Clearing a channel's enable does not stop it at once: the count drains for a short, fixed number of timer-clock cycles first, so software must wait a few ticks of a free-running channel before it relies on the stop.

A common use keeps one channel free-running with an all-ones interval, as a timestamp source, and programs the other for periodic or single events.

Top module: `dctimer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The enable mask is at 0x00 and the status is at 0x04 (bit n belongs to channel n). Channel n has control at 0x20n+0x10, interval low/high at +0x14/+0x18 and count low/high at +0x1C/+0x20. Control bit 0 is enable, bit 1 is reload, bits 6:4 are the prescaler code and bit 7 is one-shot. Bit 1 always reads 0 and the interval words read back as written.
- R3: A control write with both bit 0 and bit 1 set loads the count from the interval at that edge. With prescaler code 0, the count then falls by one on every following clock edge.
- R4: With prescaler code k, the count falls by one on every 2^k-th clock edge after the start.
- R5: A decrement from 1 to 0 sets the channel's status bit. The bit stays set until a one is written to it, and writing a zero leaves it unchanged.
- R6: In periodic mode (bit 7 clear), the tick after the count reaches zero reloads the interval, so an interval I gives one status event every I+1 ticks.
- R7: In one-shot mode (bit 7 set), reaching zero clears the channel's enable bit and the count holds at zero. No further status event follows.
- R8: `irq` is high exactly when some channel has both its status bit and its mask bit set.
- R9: An interval write to a running channel leaves the current count alone and takes effect at the next reload.
- R10: After a control write that clears enable, the count still falls on the accepting edge and on two more edges (code 0), then holds. A control write with enable set and reload clear resumes from the held value, starting on the edge after the write.
- R11: With the low interval word all ones and the high word zero, started in periodic mode, the bitwise inverse of the low count word starts at zero and rises by one per tick.
- R12: A zero interval in periodic mode never sets the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
A write takes effect at the rising edge that accepts it, so a newly loaded count reads back right after that edge. With code 0, each later edge lowers the count by one. A status flag and the interrupt change at the same edge where the count reaches zero, and the periodic reload appears one tick later. A disable still lets the count fall on the accepting edge plus two more, and a plain re-enable counts from the edge after it. The bench drives inputs at the falling edge, reads one nanosecond later, and counts edges from the write that started each case, so each expected value is sampled in the cycle these delays give.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// tmr_pkg: register offsets and control-bit positions shared by the timer
// top and its bench-visible map. Assumes byte addressing with 32-bit words.
package tmr_pkg;
    localparam int OFS_IEN    = 'h00;
    localparam int OFS_STS    = 'h04;
    localparam int CH_BASE    = 'h10;
    localparam int CH_STRIDE  = 'h20;
    localparam int REG_CTL    = 'h00;
    localparam int REG_IVL_LO = 'h04;
    localparam int REG_IVL_HI = 'h08;
    localparam int REG_CNT_LO = 'h0C;
    localparam int REG_CNT_HI = 'h10;

    localparam int CTL_EN      = 0;
    localparam int CTL_RELOAD  = 1;
    localparam int CTL_PSC_LSB = 4;
    localparam int CTL_ONESHOT = 7;

    // Byte address of register off inside channel ch.
    function automatic int reg_addr(input int ch, input int off);
        return CH_BASE + CH_STRIDE * ch + off;
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
// tmr_prescale: divides the running clock by 2^psc and emits a one-cycle
// tick. Assumes restart takes priority and that psc changes only between
// counts; the divider phase resets to zero on restart.
module tmr_prescale #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int PRE_W = (1 << PSC_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   pow2;
    logic [PRE_W-1:0] mask;

    // Low psc bits of the mask are ones.
    always_comb begin
        pow2 = (PRE_W+1)'(1) << psc;
        mask = PRE_W'(pow2 - (PRE_W+1)'(1));
    end

    assign tick = run && ((pre_q & mask) == mask);

    // Divider phase: cleared at restart, advanced while running.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_q <= '0;
        else if (restart)  pre_q <= '0;
        else if (run)      pre_q <= pre_q + PRE_W'(1);
    end

    // R4
    psc_zero_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && run && $past(run) && $past(tick) && psc == '0) |-> tick);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// tmr_channel: one 2*WORD_W-bit down-counter with interval, control state,
// one-shot/periodic expiry and a delayed stop. Assumes the caller decodes
// the bus and passes the control fields as separate strobed inputs.
module tmr_channel #(
    parameter int WORD_W   = 32,
    parameter int PSC_W    = 3,
    parameter int STOP_DLY = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic                ctl_en,
    input  logic                ctl_reload,
    input  logic                ctl_oneshot,
    input  logic [PSC_W-1:0]    ctl_psc,
    input  logic                ivl_lo_we,
    input  logic                ivl_hi_we,
    input  logic [WORD_W-1:0]   wdata,
    output logic                en_o,
    output logic                oneshot_o,
    output logic [PSC_W-1:0]    psc_o,
    output logic [2*WORD_W-1:0] ivl_o,
    output logic [2*WORD_W-1:0] cnt_o,
    output logic                expire_o
);
    localparam int CNT_W = 2 * WORD_W;
    localparam int DRN_W = $clog2(STOP_DLY + 1);

    logic             en_q, oneshot_q;
    logic [PSC_W-1:0] psc_q;
    logic [DRN_W-1:0] drain_q;
    logic [CNT_W-1:0] ivl_q, cnt_q;
    logic             start, run, tick, cnt_one, cnt_zero;

    assign start    = ctl_we && ctl_en && ctl_reload;
    assign run      = en_q || (drain_q != '0);
    assign cnt_one  = (cnt_q == CNT_W'(1));
    assign cnt_zero = (cnt_q == '0);
    assign expire_o = tick && cnt_one && !start;

    tmr_prescale #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start),
        .run     (run),
        .psc     (psc_q),
        .tick    (tick)
    );

    // Control state: bus writes, one-shot self-stop and the stop drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            oneshot_q <= 1'b0;
            psc_q     <= '0;
            drain_q   <= '0;
        end else if (ctl_we) begin
            en_q      <= ctl_en;
            oneshot_q <= ctl_oneshot;
            psc_q     <= ctl_psc;
            if (en_q && !ctl_en)     drain_q <= DRN_W'(STOP_DLY);
            else if (ctl_en)         drain_q <= '0;
            else if (drain_q != '0)  drain_q <= drain_q - DRN_W'(1);
        end else begin
            if (tick && oneshot_q && (cnt_one || cnt_zero)) en_q <= 1'b0;
            if (drain_q != '0) drain_q <= drain_q - DRN_W'(1);
        end
    end

    // Interval words: written independently, never touch the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl_q <= '0;
        end else begin
            if (ivl_lo_we) ivl_q[WORD_W-1:0]      <= wdata;
            if (ivl_hi_we) ivl_q[CNT_W-1:WORD_W]  <= wdata;
        end
    end

    // Count: load on start, reload or hold at zero, else decrement per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= ivl_q;
        end else if (tick) begin
            if (cnt_zero) begin
                if (!oneshot_q) cnt_q <= ivl_q;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign en_o      = en_q;
    assign oneshot_o = oneshot_q;
    assign psc_o     = psc_q;
    assign ivl_o     = ivl_q;
    assign cnt_o     = cnt_q;

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tick) |=> $stable(cnt_q));
    // R10
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && drain_q == '0) |-> !tick);
    // R6
    periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_zero && !oneshot_q && !start) |=> (cnt_q == $past(ivl_q)));
    // R7
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && oneshot_q && !ctl_we) |=> (!en_q && cnt_q == '0));
endmodule

// File: rtl/dctimer.sv
`timescale 1ns/1ps
// dctimer: multi-channel countdown timer with a register bus, a shared
// interrupt mask and a write-one-to-clear status word. Assumes one clock for
// bus and counting; reads are combinational from the address.
module dctimer #(
    parameter int NCH      = 2,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int PSC_W    = 3,
    parameter int STOP_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    import tmr_pkg::*;

    logic [NCH-1:0]             ie_q, sts_q, sts_nxt, exp_v;
    logic [NCH-1:0][WORD_W-1:0] rd_v;
    logic                       a_ien, a_sts;

    assign a_ien = (bus_addr == ADDR_W'(OFS_IEN));
    assign a_sts = (bus_addr == ADDR_W'(OFS_STS));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic                a_ctl, a_ill, a_ilh, a_cnl, a_cnh;
        logic                en, os;
        logic [PSC_W-1:0]    psc;
        logic [2*WORD_W-1:0] ivl, cnt;
        logic [WORD_W-1:0]   ctl_word;

        assign a_ctl = (bus_addr == ADDR_W'(reg_addr(n, REG_CTL)));
        assign a_ill = (bus_addr == ADDR_W'(reg_addr(n, REG_IVL_LO)));
        assign a_ilh = (bus_addr == ADDR_W'(reg_addr(n, REG_IVL_HI)));
        assign a_cnl = (bus_addr == ADDR_W'(reg_addr(n, REG_CNT_LO)));
        assign a_cnh = (bus_addr == ADDR_W'(reg_addr(n, REG_CNT_HI)));

        tmr_channel #(.WORD_W(WORD_W), .PSC_W(PSC_W), .STOP_DLY(STOP_DLY)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .ctl_we      (bus_we && a_ctl),
            .ctl_en      (bus_wdata[CTL_EN]),
            .ctl_reload  (bus_wdata[CTL_RELOAD]),
            .ctl_oneshot (bus_wdata[CTL_ONESHOT]),
            .ctl_psc     (bus_wdata[CTL_PSC_LSB +: PSC_W]),
            .ivl_lo_we   (bus_we && a_ill),
            .ivl_hi_we   (bus_we && a_ilh),
            .wdata       (bus_wdata),
            .en_o        (en),
            .oneshot_o   (os),
            .psc_o       (psc),
            .ivl_o       (ivl),
            .cnt_o       (cnt),
            .expire_o    (exp_v[n])
        );

        // Control readback: reload is a command and always reads zero.
        always_comb begin
            ctl_word                          = '0;
            ctl_word[CTL_EN]                  = en;
            ctl_word[CTL_ONESHOT]             = os;
            ctl_word[CTL_PSC_LSB +: PSC_W]    = psc;
        end

        assign rd_v[n] = a_ctl ? ctl_word :
                         a_ill ? ivl[WORD_W-1:0] :
                         a_ilh ? ivl[2*WORD_W-1:WORD_W] :
                         a_cnl ? cnt[WORD_W-1:0] :
                         a_cnh ? cnt[2*WORD_W-1:WORD_W] : '0;
    end

    // Status next state: expiry sets and wins over a same-cycle clear.
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            if (exp_v[n])                           sts_nxt[n] = 1'b1;
            else if (bus_we && a_sts && bus_wdata[n]) sts_nxt[n] = 1'b0;
            else                                    sts_nxt[n] = sts_q[n];
        end
    end

    // Mask and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= '0;
            sts_q <= '0;
        end else begin
            if (bus_we && a_ien) ie_q <= bus_wdata[NCH-1:0];
            sts_q <= sts_nxt;
        end
    end

    // Read mux: unselected channels contribute zero.
    always_comb begin
        bus_rdata = '0;
        if (a_ien) bus_rdata = WORD_W'(ie_q);
        if (a_sts) bus_rdata = WORD_W'(sts_q);
        for (int n = 0; n < NCH; n++) bus_rdata = bus_rdata | rd_v[n];
    end

    assign irq = |(sts_q & ie_q);

    // R5
    sts_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & ~$past(sts_q)) != '0) |-> ($past(exp_v) != '0));
endmodule

// File: tb/dctimer_tb.sv
`timescale 1ns/1ps
module dctimer_tb_top;
    localparam logic [7:0] A_IEN  = 8'h00, A_STS  = 8'h04;
    localparam logic [7:0] A_CTL0 = 8'h10, A_IL0  = 8'h14, A_IH0 = 8'h18;
    localparam logic [7:0] A_CL0  = 8'h1C, A_CH0  = 8'h20;
    localparam logic [7:0] A_CTL1 = 8'h30, A_IL1  = 8'h34, A_IH1 = 8'h38;
    localparam logic [7:0] A_CL1  = 8'h3C, A_CH1  = 8'h40;

    typedef struct packed {
        logic [2:0]  psc;
        logic [31:0] ih;
        logic [31:0] il;
        logic [15:0] n;
        logic [31:0] eh;
        logic [31:0] el;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 32'd0, 32'd100,  16'd10,  32'd0, 32'd90},
        '{3'd1, 32'd0, 32'd100,  16'd10,  32'd0, 32'd95},
        '{3'd2, 32'd0, 32'd50,   16'd20,  32'd0, 32'd45},
        '{3'd3, 32'd0, 32'd1000, 16'd64,  32'd0, 32'd992},
        '{3'd7, 32'd0, 32'd5,    16'd256, 32'd0, 32'd3},
        '{3'd0, 32'd1, 32'd2,    16'd3,   32'd0, 32'hFFFF_FFFF}
    };

    logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    dctimer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        #1;
        chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd("R1 ien", A_IEN, 0);
        chk_rd("R1 sts", A_STS, 0);
        chk_rd("R1 ctl0", A_CTL0, 0);
        chk_rd("R1 ctl1", A_CTL1, 0);
        chk_rd("R1 cnt0", A_CL0, 0);
        chk_rd("R1 ivl1", A_IL1, 0);
        chk_irq("R1 irq", 1'b0);

        // R2 register map and readback
        wr(A_IL1, 32'hA5A5_0001);
        wr(A_IH1, 32'h0000_0077);
        chk_rd("R2 ivl lo", A_IL1, 32'hA5A5_0001);
        chk_rd("R2 ivl hi", A_IH1, 32'h0000_0077);
        wr(A_CTL1, 32'h0000_00D2);
        chk_rd("R2 ctl fields", A_CTL1, 32'h0000_00D0);
        chk_rd("R2 no start", A_CL1, 0);
        wr(A_IH1, 0);

        // R3/R4 vector table on channel 0
        for (int i = 0; i < 6; i++) begin
            wr(A_IH0, VECS[i].ih);
            wr(A_IL0, VECS[i].il);
            wr(A_CTL0, {24'b0, 1'b0, VECS[i].psc, 4'b0011});
            wait_n(int'(VECS[i].n));
            chk_rd((VECS[i].psc == 3'd0) ? "R3 cnt lo" : "R4 cnt lo", A_CL0, VECS[i].el);
            chk_rd((VECS[i].psc == 3'd0) ? "R3 cnt hi" : "R4 cnt hi", A_CH0, VECS[i].eh);
        end

        // R5/R6/R8 periodic expiry, sticky status, mask
        wr(A_IH0, 0);
        wr(A_IL0, 3);
        wr(A_CTL0, 32'h03);
        wait_n(2);
        chk_rd("R5 cnt before zero", A_CL0, 1);
        chk_rd("R5 sts before zero", A_STS, 0);
        wait_n(1);
        chk_rd("R5 cnt zero", A_CL0, 0);
        chk_rd("R5 sts set", A_STS, 1);
        chk_irq("R8 masked", 1'b0);
        wait_n(1);
        chk_rd("R6 reload", A_CL0, 3);
        wr(A_STS, 0);
        chk_rd("R5 zero write no clear", A_STS, 1);
        wr(A_IEN, 1);
        chk_irq("R8 unmasked", 1'b1);
        chk_rd("R6 counting", A_CL0, 1);
        wait_n(2);
        chk_rd("R6 second reload", A_CL0, 3);
        wr(A_STS, 1);
        chk_rd("R5 w1c", A_STS, 0);
        chk_irq("R8 cleared", 1'b0);

        // R7 one-shot
        wr(A_IL0, 2);
        wr(A_CTL0, 32'h83);
        chk_rd("R7 loaded", A_CL0, 2);
        chk_rd("R7 no sts at start", A_STS, 0);
        wait_n(2);
        chk_rd("R7 zero", A_CL0, 0);
        chk_rd("R7 sts", A_STS, 1);
        chk_rd("R7 en cleared", A_CTL0, 32'h80);
        wait_n(4);
        chk_rd("R7 holds", A_CL0, 0);
        wr(A_STS, 1);
        wait_n(3);
        chk_rd("R7 no second event", A_STS, 0);
        chk_rd("R7 still zero", A_CL0, 0);

        // R9 interval write while running
        wr(A_IL0, 10);
        wr(A_CTL0, 32'h03);
        wait_n(2);
        wr(A_IL0, 4);
        chk_rd("R9 count undisturbed", A_CL0, 7);
        wait_n(7);
        chk_rd("R9 zero", A_CL0, 0);
        wait_n(1);
        chk_rd("R9 new interval at reload", A_CL0, 4);

        // R10 delayed stop and resume on channel 1
        wr(A_IL1, 100);
        wr(A_CTL1, 32'h03);
        wait_n(5);
        chk_rd("R10 running", A_CL1, 95);
        wr(A_CTL1, 0);
        chk_rd("R10 accept edge counts", A_CL1, 94);
        chk_rd("R10 en reads 0", A_CTL1, 0);
        wait_n(2);
        chk_rd("R10 drain", A_CL1, 92);
        wait_n(3);
        chk_rd("R10 held", A_CL1, 92);
        wr(A_CTL1, 32'h01);
        chk_rd("R10 resume edge", A_CL1, 92);
        wait_n(1);
        chk_rd("R10 resumed", A_CL1, 91);

        // R11 free-running timestamp
        wr(A_IL1, 32'hFFFF_FFFF);
        wr(A_CTL1, 32'h03);
        addr = A_CL1; #1;
        chk("R11 start", ~rdata, 0);
        chk_rd("R11 hi", A_CH1, 0);
        wait_n(5);
        addr = A_CL1; #1;
        chk("R11 rising", ~rdata, 5);
        wait_n(7);
        addr = A_CL1; #1;
        chk("R11 rising more", ~rdata, 12);

        // R12 zero interval
        wr(A_IL1, 0);
        wr(A_CTL1, 32'h03);
        wait_n(6);
        addr = A_STS; #1;
        chk("R12 no status", rdata & 32'h2, 0);
        chk_rd("R12 count zero", A_CL1, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule